// File: doc/BRIEF.md
# Addressed Two-Wire Configuration Register Slave

This block is the configuration and readout port of one front-end chip. Each chip gets its own address on a shared two-wire bus, so a board controller can reach any chip directly. This replaces passing a long bit stream through a chain of chips. The bus master drives the clock line (SCL) alone. The data line (SDA) is a wired-AND line. The slave only ever pulls it low and otherwise leaves it released.

A transaction opens with a START. The first byte carries a seven-bit device address and a direction bit. The address is a fixed `1010` prefix followed by three bits taken from strap pins.

- On a write, the next byte sets an internal register pointer. Every byte after that is stored at the pointer, and the pointer then steps forward.
- On a read, the slave returns the register at the pointer. It keeps returning the next register for as long as the master acknowledges.

Configuration can therefore be read back without being written again. The whole register array is exposed to the rest of the chip as one flat vector.

Both bus lines pass through a two-flop synchroniser into the system clock domain. START, STOP and the SCL edges are all detected on the synchronised copies. A START or STOP resets the byte machine at any point, even in the middle of a byte.

Top module: `cfg_serial_slave`

## Requirements
- R1: During and after reset the slave does not pull SDA (`sda_pull_o` = 0), and every register reads 0 on `regs_o`.
- R2: The slave acknowledges the first byte after a START only when its bits 7..1, sent MSB first, equal `1010` followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]`. It acknowledges by pulling SDA low for the whole high phase of the ninth clock. Bit 0 of that byte is the direction: 0 means write, 1 means read.
- R3: After a non-matching address the slave never pulls SDA until the next START, and no register changes.
- R4: In a write, the second byte sets the pointer from its low log2(NREG) bits, and the third byte is stored at that pointer. Register k occupies `regs_o[8k+7:8k]`. The slave acknowledges every byte it receives in a write.
- R5: In a write burst, the pointer advances by one after each stored byte and wraps from NREG-1 to 0.
- R6: In a read, the slave sends the register at the pointer MSB first. It changes SDA only while SCL is low, and the pointer advances by one after each byte sent.
- R7: If the master acknowledges a read byte (SDA low on the ninth clock), the slave sends the next register. If it does not (SDA high), the slave releases SDA and drives nothing until the next START.
- R8: A START or STOP that arrives in the middle of a byte abandons that byte and writes no register. A START always begins a new address phase, and a STOP returns the slave to idle.
- R9: A read, including the register-pointer write that comes before it, leaves every register unchanged. The pointer keeps its value across STOP, so a read with no register byte continues from where the last transfer ended.
- R10: The slave begins pulling SDA only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| strap_i | input | 3 | Strap pins forming the low three bits of the device address |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| regs_o | output | NREG*8 | All registers; register k at bits 8k+7..8k |

## Verification
In a write burst, three things happen on the same system clock: the register-file store, the pointer increment and the start of the acknowledge drive. This is the SCL falling edge that ends each data byte. Bursts that run across the top of the array provoke this case. The flat register vector is compared with a bench model after every STOP, so a slipped, repeated or skipped pointer step shows up at once.

The second collision is a START or STOP landing while the byte machine is partway through a byte. Directed aborts cover this, both mid-address and mid-data. The bench judges it by whether the register vector stays unchanged and whether the address phase that follows is still acknowledged.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int           BYTE_W     = 8;
    localparam logic [3:0]   DEV_PREFIX = 4'b1010;
    localparam logic [3:0]   BITS_DONE  = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_REGADDR,
        ST_WDATA,
        ST_RDATA,
        ST_ACK_OUT,
        ST_ACK_IN,
        ST_IGNORE
    } link_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                       input logic [2:0]        strap);
        return b[BYTE_W-1:1] == {DEV_PREFIX, strap};
    endfunction

    function automatic logic is_read(input logic [BYTE_W-1:0] b);
        return b[0];
    endfunction
endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync
    import cfgs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q[0] <= scl_i;
            sda_q[0] <= sda_i;
            for (int k = 1; k < STAGES; k++) begin
                scl_q[k] <= scl_q[k-1];
                sda_q[k] <= sda_q[k-1];
            end
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
    import cfgs_pkg::*;
#(
    parameter int NREG = 16,
    parameter int PTRW = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [PTRW-1:0]          waddr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic [PTRW-1:0]          raddr,
    output logic [BYTE_W-1:0]        rdata,
    output logic [NREG*BYTE_W-1:0]   flat
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [BYTE_W-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (we && waddr == PTRW'(g)) begin
                mem[g] <= wdata;
            end
        end
        assign flat[g*BYTE_W +: BYTE_W] = mem[g];
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cfgs_link_fsm.sv
module cfgs_link_fsm
    import cfgs_pkg::*;
#(
    parameter int PTRW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt,
    input  logic [2:0]         strap,
    input  logic [BYTE_W-1:0]  rdata,
    output logic               we,
    output logic [PTRW-1:0]    waddr,
    output logic [BYTE_W-1:0]  wdata,
    output logic [PTRW-1:0]    raddr,
    output logic               sda_pull,
    output link_state_e        state
);
    timeunit 1ns;
    timeprecision 100ps;

    link_state_e        after_ack;
    logic [3:0]         cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [PTRW-1:0]    ptr;
    logic               master_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            after_ack  <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            ptr        <= '0;
            master_ack <= 1'b0;
            sda_pull   <= 1'b0;
            we         <= 1'b0;
            waddr      <= '0;
            wdata      <= '0;
        end else begin
            we <= 1'b0;
            if (evt.start) begin
                state    <= ST_DEVADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
                        if (evt.scl_rise && cnt < BITS_DONE) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == BITS_DONE) begin
                            cnt <= '0;
                            if (state == ST_DEVADDR) begin
                                if (dev_match(shreg, strap)) begin
                                    sda_pull  <= 1'b1;
                                    state     <= ST_ACK_OUT;
                                    after_ack <= is_read(shreg) ? ST_RDATA : ST_REGADDR;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_REGADDR) begin
                                ptr       <= shreg[PTRW-1:0];
                                sda_pull  <= 1'b1;
                                state     <= ST_ACK_OUT;
                                after_ack <= ST_WDATA;
                            end else begin
                                we        <= 1'b1;
                                waddr     <= ptr;
                                wdata     <= shreg;
                                ptr       <= ptr + 1'b1;
                                sda_pull  <= 1'b1;
                                state     <= ST_ACK_OUT;
                                after_ack <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK_OUT: begin
                        if (evt.scl_fall) begin
                            state <= after_ack;
                            cnt   <= '0;
                            if (after_ack == ST_RDATA) begin
                                shreg    <= rdata;
                                sda_pull <= ~rdata[BYTE_W-1];
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_fall) begin
                            if (cnt == BITS_DONE - 4'd1) begin
                                sda_pull <= 1'b0;
                                state    <= ST_ACK_IN;
                                ptr      <= ptr + 1'b1;
                                cnt      <= '0;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                                cnt      <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_ACK_IN: begin
                        if (evt.scl_rise) begin
                            master_ack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (master_ack) begin
                                shreg    <= rdata;
                                sda_pull <= ~rdata[BYTE_W-1];
                                state    <= ST_RDATA;
                                cnt      <= '0;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign raddr = ptr;
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgs_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic [2:0]              strap_i,
    output logic                    sda_pull_o,
    output logic [NREG*BYTE_W-1:0]  regs_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PTRW = (NREG > 1) ? $clog2(NREG) : 1;

    bus_evt_t           evt;
    logic               we;
    logic [PTRW-1:0]    waddr;
    logic [BYTE_W-1:0]  wdata;
    logic [PTRW-1:0]    raddr;
    logic [BYTE_W-1:0]  rdata;
    link_state_e        state;

    logic scl_s;
    logic start_ev;
    logic stop_ev;
    logic scl_fall_ev;

    cfgs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    cfgs_link_fsm #(.PTRW(PTRW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .strap    (strap_i),
        .rdata    (rdata),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .raddr    (raddr),
        .sda_pull (sda_pull_o),
        .state    (state)
    );

    cfgs_regfile #(.NREG(NREG), .PTRW(PTRW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata),
        .flat  (regs_o)
    );

    assign scl_s       = evt.scl;
    assign start_ev    = evt.start;
    assign stop_ev     = evt.stop;
    assign scl_fall_ev = evt.scl_fall;
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker
    import cfgs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        sda_pull,
    input logic        scl_s,
    input logic        start_ev,
    input logic        stop_ev,
    input logic        scl_fall_ev,
    input logic        we,
    input link_state_e state
);
    timeunit 1ns;
    timeprecision 100ps;

    assert_reset_release_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_pull && state == ST_IDLE));

    assert_ack_drive_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK_OUT) |-> sda_pull);

    assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_pull);

    assert_write_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        we |-> $past(scl_fall_ev));

    assert_start_addr_R8: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (state == ST_DEVADDR));

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (state == ST_IDLE && !sda_pull));

    assert_read_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDATA || state == ST_ACK_IN) |-> !we);

    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_s);
endmodule

bind cfg_serial_slave cfgs_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sda_pull    (sda_pull_o),
    .scl_s       (scl_s),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .scl_fall_ev (scl_fall_ev),
    .we          (we),
    .state       (state)
);

// File: tb/cfg_serial_slave_tb_top.sv
module cfg_serial_slave_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NREG = 16;
    localparam int PW   = 4;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b000;
    logic sda_pull;
    logic [NREG*8-1:0] regs;
    logic sda_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0]    mdl [NREG];
    logic [PW-1:0] mptr;

    assign sda_line = sda_m & ~sda_pull;

    always #2.5 clk = ~clk;

    cfg_serial_slave #(.NREG(NREG), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_pull_o (sda_pull),
        .regs_o     (regs)
    );

    function automatic logic [7:0] dev_byte(logic [2:0] s, logic rw);
        return {4'b1010, s, rw};
    endfunction

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] v;
        for (int k = 0; k < NREG; k++) v[k*8 +: 8] = mdl[k];
        return v;
    endfunction

    task automatic check(string req, logic [NREG*8-1:0] act, logic [NREG*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(logic b);
        sda_m = b;  tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic put_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        acked = !sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic get_byte(logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl = 1'b1;   tick(Q);
            d[i] = sda_line;
            tick(Q);
            scl = 1'b0;   tick(Q);
        end
        put_bit(!give_ack);
    endtask

    task automatic do_write(logic [7:0] ra, int n);
        logic a;
        logic [7:0] d;
        bus_start();
        put_byte(dev_byte(strap, 1'b0), a);
        check("R2 address ack", a, 1);
        put_byte(ra, a);
        check("R4 register byte ack", a, 1);
        mptr = ra[PW-1:0];
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            put_byte(d, a);
            check("R4 data byte ack", a, 1);
            mdl[mptr] = d;
            mptr = mptr + 1'b1;
        end
        bus_stop();
        check("R4/R5 register contents after write", regs, model_flat());
    endtask

    task automatic do_read(bit set_ptr, logic [7:0] ra, int n);
        logic a;
        logic [7:0] d;
        bus_start();
        if (set_ptr) begin
            put_byte(dev_byte(strap, 1'b0), a);
            check("R2 address ack", a, 1);
            put_byte(ra, a);
            check("R4 register byte ack", a, 1);
            mptr = ra[PW-1:0];
            bus_start();
        end
        put_byte(dev_byte(strap, 1'b1), a);
        check("R2 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k < n - 1, d);
            check("R6/R7 read data", d, mdl[mptr]);
            mptr = mptr + 1'b1;
        end
        // R7: after NACK the line must stay released for a further clock
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        check("R7 released after nack", sda_line, 1);
        tick(Q);
        scl = 1'b0;   tick(Q);
        bus_stop();
        check("R9 registers unchanged by read", regs, model_flat());
    endtask

    task automatic do_wrong_addr();
        logic a;
        logic [6:0] wa;
        do wa = 7'($urandom); while (wa == {4'b1010, strap});
        bus_start();
        put_byte({wa, 1'($urandom)}, a);
        check("R2/R3 no ack on wrong address", a, 0);
        put_byte(8'($urandom), a);
        check("R3 no ack after mismatch", a, 0);
        put_byte(8'($urandom), a);
        check("R3 no ack after mismatch", a, 0);
        bus_stop();
        check("R3 registers unchanged", regs, model_flat());
    endtask

    task automatic do_abort_data(logic [7:0] ra);
        logic a;
        bus_start();
        put_byte(dev_byte(strap, 1'b0), a);
        check("R8 address ack", a, 1);
        put_byte(ra, a);
        check("R8 register byte ack", a, 1);
        mptr = ra[PW-1:0];
        for (int i = 0; i < 5; i++) put_bit(1'($urandom));
        bus_stop();
        check("R8 no write on aborted byte", regs, model_flat());
    endtask

    task automatic do_abort_addr();
        for (int i = 0; i < 3; i++) put_bit(1'($urandom));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic a;
        void'($urandom(32'd24681));
        for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
        mptr = '0;
        tick(6);
        check("R1 pull released in reset", sda_pull, 0);
        rst = 1'b0;
        tick(4);
        check("R1 registers zero after reset", regs, '0);
        check("R1 pull released after reset", sda_pull, 0);

        strap = 3'b101;
        do_write(8'h03, 1);
        do_read(1'b1, 8'h03, 1);
        // R5: wrap from the top of the array
        do_write(8'(NREG - 2), 4);
        do_read(1'b1, 8'(NREG - 2), 4);
        // R4: upper bits of the register byte are ignored
        do_write(8'hF7, 2);
        do_read(1'b1, 8'h07, 2);
        // R9: read continuing from the retained pointer
        do_read(1'b0, 8'h00, 2);
        do_wrong_addr();
        do_abort_data(8'h05);
        // R8: start mid-address, then a clean write must still work
        bus_start();
        do_abort_addr();
        do_write(8'h0A, 1);
        do_read(1'b1, 8'h0A, 1);

        for (int it = 0; it < 30; it++) begin
            int op;
            strap = 3'($urandom);
            op = int'($urandom % 5);
            case (op)
                0, 1: do_write(8'($urandom), 1 + int'($urandom % 3));
                2:    do_read(1'b1, 8'($urandom), 1 + int'($urandom % 3));
                3:    do_read(1'b0, 8'h00, 1 + int'($urandom % 2));
                default: do_wrong_addr();
            endcase
        end

        bus_start();
        put_byte(dev_byte(strap, 1'b1), a);
        check("R2 final address ack", a, 1);
        bus_stop();
        check("R8 stop releases line", sda_pull, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule